// File: doc/BRIEF.md
# UART Receive Idle Timeout Detector

This block watches a UART receiver after every completed character. It then counts how long the line stays idle. Time is measured in whole character periods. The length of one period follows the configured frame format: one start bit, 5 to 9 data bits, an optional parity bit, and one or two stop bits. A bit-tick strobe running at the baud rate drives the count.

When a programmed number of idle characters has elapsed and no new character has started, the block does two things. It emits a one-cycle frame-close pulse, which the buffer logic uses to close the current receive buffer. It also latches an interrupt flag, which can be masked.

The idle count is armed only by a received character. A start bit on the line cancels it. Each idle period can produce at most one timeout. Writing a zero maximum-idle value turns the whole feature off.

Top module: `uart_idle_timeout`

## Requirements
- R1: After reset, no idle counting takes place and `timeout_pulse` stays 0 until `char_done` has been seen, whatever `bit_tick` does.
- R2: One idle character lasts L = 1 + `cfg_data_bits` + `cfg_parity_en` + (`cfg_two_stop` ? 2 : 1) bit ticks. Examples: 8N1 gives 10, 5N1 gives 7, and 9 data bits with parity and 2 stop bits gives 13.
- R3: After `char_done` with `max_idle` = N > 0, `timeout_pulse` rises for exactly one clock cycle. It does so in the cycle after the clock edge that samples bit tick number N*L. Tick number N*L-1 never causes it.
- R4: If `max_idle` is 0 when `char_done` is sampled, no timeout occurs in that idle period.
- R5: Each idle period produces at most one timeout. Further bit ticks give no further pulse until another `char_done` arrives.
- R6: A falling edge on `rx_line` (a start bit) cancels the idle count. No timeout follows until the next `char_done`.
- R7: A `char_done` during an idle period reloads the counter from `max_idle` and restarts the bit count from zero.
- R8: When a timeout occurs while `irq_en` is 1, `irq_flag` becomes 1 in the same cycle as the pulse. It then stays 1 until a cycle in which `irq_clr` is 1.
- R9: When `irq_en` is 0, a timeout still produces `timeout_pulse` but leaves `irq_flag` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Synchronized receive line, idle high |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| char_done | input | 1 | One-cycle strobe when a character has been received |
| cfg_data_bits | input | 4 | Data bits per character (5 to 9) |
| cfg_parity_en | input | 1 | Parity bit present |
| cfg_two_stop | input | 1 | Two stop bits when 1, one when 0 |
| max_idle | input | 16 | Idle characters before timeout, 0 disables |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt flag |
| timeout_pulse | output | 1 | One-cycle frame-close pulse |
| irq_flag | output | 1 | Sticky interrupt request |

## Verification
The count logic is exercised with several frame formats (8N1, 5N1, 7E1 and 9 data bits with parity and 2 stop bits) and with several maximum-idle values. Each case is driven to one tick short of the threshold and then to exactly the threshold. This separates a correct character length from an off-by-one count or a wrong parity and stop-bit contribution.

A long run of ticks past the threshold distinguishes one-shot behaviour from a counter that wraps and fires again. A zero maximum-idle value checks the disable. Start-bit edges and mid-period characters separate cancellation from reloading. Runs with the interrupt enabled and disabled, followed by clearing, separate the pulse path from the sticky flag.

// File: rtl/uart_idle_pkg.sv
package uart_idle_pkg;
  localparam int IDLE_W   = 16;
  localparam int BITCNT_W = 4;

  function automatic logic [BITCNT_W-1:0] char_bits(
    input logic [3:0] data_bits,
    input logic       parity_en,
    input logic       two_stop
  );
    logic [BITCNT_W-1:0] sum;
    sum = BITCNT_W'(1) + BITCNT_W'(data_bits) + BITCNT_W'(parity_en)
        + (two_stop ? BITCNT_W'(2) : BITCNT_W'(1));
    return sum;
  endfunction
endpackage

// File: rtl/idle_edge_det.sv
module idle_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_line,
  output logic start_edge
);
  logic rx_prev_q;
  logic rx_prev_d;

  always_comb begin
    rx_prev_d  = rx_line;
    start_edge = rx_prev_q & ~rx_line;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_prev_q <= 1'b1;
    else        rx_prev_q <= rx_prev_d;
  end
endmodule

// File: rtl/idle_bit_timer.sv
module idle_bit_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             bit_tick,
  input  logic [CNT_W-1:0] char_len,
  output logic             char_tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last_bit;

  always_comb begin
    last_bit  = (cnt_q == char_len - CNT_W'(1));
    char_tick = run & bit_tick & last_bit;
    cnt_d     = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (run && bit_tick)
      cnt_d = last_bit ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/idle_char_counter.sv
module idle_char_counter #(
  parameter int IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              cancel,
  input  logic              char_tick,
  input  logic [IDLE_W-1:0] max_idle,
  output logic              armed,
  output logic              fire
);
  logic [IDLE_W-1:0] cnt_q, cnt_d;
  logic              armed_q, armed_d;
  logic              last_char;

  always_comb begin
    last_char = (cnt_q == IDLE_W'(1));
    armed_d   = armed_q;
    cnt_d     = cnt_q;
    fire      = 1'b0;
    if (load) begin
      armed_d = (max_idle != '0);
      cnt_d   = max_idle;
    end else if (cancel) begin
      armed_d = 1'b0;
    end else if (armed_q && char_tick) begin
      cnt_d = cnt_q - IDLE_W'(1);
      if (last_char) begin
        armed_d = 1'b0;
        fire    = 1'b1;
      end
    end
  end

  assign armed = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/idle_irq_flag.sv
module idle_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic irq_en,
  input  logic irq_clr,
  output logic timeout_pulse,
  output logic irq_flag
);
  logic pulse_q, pulse_d;
  logic flag_q, flag_d;

  always_comb begin
    pulse_d = fire;
    if (fire && irq_en) flag_d = 1'b1;
    else if (irq_clr)   flag_d = 1'b0;
    else                flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
      flag_q  <= flag_d;
    end
  end

  assign timeout_pulse = pulse_q;
  assign irq_flag      = flag_q;
endmodule

// File: rtl/uart_idle_timeout.sv
module uart_idle_timeout
  import uart_idle_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              bit_tick,
  input  logic              char_done,
  input  logic [3:0]        cfg_data_bits,
  input  logic              cfg_parity_en,
  input  logic              cfg_two_stop,
  input  logic [IDLE_W-1:0] max_idle,
  input  logic              irq_en,
  input  logic              irq_clr,
  output logic              timeout_pulse,
  output logic              irq_flag
);
  logic                start_edge;
  logic                char_tick;
  logic                armed;
  logic                fire;
  logic                bit_clr;
  logic [BITCNT_W-1:0] char_len;

  always_comb begin
    char_len = char_bits(cfg_data_bits, cfg_parity_en, cfg_two_stop);
    bit_clr  = char_done | ~armed;
  end

  idle_edge_det u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_line    (rx_line),
    .start_edge (start_edge)
  );

  idle_bit_timer #(.CNT_W(BITCNT_W)) u_bits (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (bit_clr),
    .run       (armed),
    .bit_tick  (bit_tick),
    .char_len  (char_len),
    .char_tick (char_tick)
  );

  idle_char_counter #(.IDLE_W(IDLE_W)) u_chars (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (char_done),
    .cancel    (start_edge),
    .char_tick (char_tick),
    .max_idle  (max_idle),
    .armed     (armed),
    .fire      (fire)
  );

  idle_irq_flag u_irq (
    .clk           (clk),
    .rst_n         (rst_n),
    .fire          (fire),
    .irq_en        (irq_en),
    .irq_clr       (irq_clr),
    .timeout_pulse (timeout_pulse),
    .irq_flag      (irq_flag)
  );
endmodule

// File: rtl/uart_idle_timeout_chk.sv
module uart_idle_timeout_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_line,
  input logic        char_done,
  input logic [15:0] max_idle,
  input logic        irq_en,
  input logic        irq_clr,
  input logic        armed,
  input logic        timeout_pulse,
  input logic        irq_flag
);
  // R3: the frame-close pulse lasts one cycle
  a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |=> !timeout_pulse);

  // R1: a pulse needs a count that was armed
  a_r1_needs_armed: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |-> $past(armed));

  // R5: once fired, the counter is disarmed
  a_r5_disarm_after: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |-> !armed);

  // R4: a zero limit leaves the counter disarmed
  a_r4_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && max_idle == 16'd0) |=> !armed);

  // R6: a start bit cancels counting
  a_r6_start_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rx_line) && !char_done) |=> !armed);

  // R8: the flag holds until it is cleared
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);

  // R9: with the interrupt disabled, the flag cannot rise
  a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en && !irq_flag) |=> !irq_flag);
endmodule

bind uart_idle_timeout uart_idle_timeout_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rx_line       (rx_line),
  .char_done     (char_done),
  .max_idle      (max_idle),
  .irq_en        (irq_en),
  .irq_clr       (irq_clr),
  .armed         (armed),
  .timeout_pulse (timeout_pulse),
  .irq_flag      (irq_flag)
);

// File: tb/uart_idle_timeout_test.sv
`timescale 1ns/1ps
module uart_idle_timeout_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_line = 1'b1;
  logic        bit_tick = 1'b0;
  logic        char_done = 1'b0;
  logic [3:0]  cfg_data_bits = 4'd8;
  logic        cfg_parity_en = 1'b0;
  logic        cfg_two_stop = 1'b0;
  logic [15:0] max_idle = 16'd1;
  logic        irq_en = 1'b1;
  logic        irq_clr = 1'b0;
  logic        timeout_pulse;
  logic        irq_flag;

  int tests = 0;
  int fails = 0;
  int pulses = 0;
  int base = 0;

  always #2.5 clk = ~clk;

  uart_idle_timeout uut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .bit_tick(bit_tick),
    .char_done(char_done), .cfg_data_bits(cfg_data_bits),
    .cfg_parity_en(cfg_parity_en), .cfg_two_stop(cfg_two_stop),
    .max_idle(max_idle), .irq_en(irq_en), .irq_clr(irq_clr),
    .timeout_pulse(timeout_pulse), .irq_flag(irq_flag)
  );

  always @(negedge clk) if (rst_n && timeout_pulse) pulses++;

  // fields: data bits[33:30] parity[29] two_stop[28] max_idle[27:12] ticks[11:4] expected pulses[3:0]
  localparam int NV = 9;
  localparam logic [33:0] VECS [NV] = '{
    {4'd8, 1'b0, 1'b0, 16'd1,  8'd9,  4'd0},  // R2 R3 8N1 one short
    {4'd8, 1'b0, 1'b0, 16'd1,  8'd10, 4'd1},  // R2 R3 8N1 exact
    {4'd5, 1'b0, 1'b0, 16'd2,  8'd13, 4'd0},  // R2 5N1 L=7
    {4'd5, 1'b0, 1'b0, 16'd2,  8'd14, 4'd1},
    {4'd9, 1'b1, 1'b1, 16'd3,  8'd38, 4'd0},  // R2 L=13
    {4'd9, 1'b1, 1'b1, 16'd3,  8'd39, 4'd1},
    {4'd7, 1'b1, 1'b0, 16'd1,  8'd10, 4'd1},  // R2 7E1 L=10
    {4'd8, 1'b0, 1'b0, 16'd0,  8'd50, 4'd0},  // R4 disabled
    {4'd8, 1'b0, 1'b0, 16'd1,  8'd45, 4'd1}   // R5 one shot
  };

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1; cyc(1);
      bit_tick = 1'b0; cyc(1);
    end
  endtask

  task automatic got_char();
    char_done = 1'b1; cyc(1);
    char_done = 1'b0;
  endtask

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_irq();
    irq_clr = 1'b1; cyc(1);
    irq_clr = 1'b0; cyc(1);
  endtask

  initial begin : watchdog
    #400000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state and no counting before a character
    check("R1 pulse after reset", int'(timeout_pulse), 0);
    check("R1 flag after reset", int'(irq_flag), 0);
    base = pulses; ticks(30); cyc(2);
    check("R1 no count before char_done", pulses - base, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      cfg_data_bits = VECS[v][33:30];
      cfg_parity_en = VECS[v][29];
      cfg_two_stop  = VECS[v][28];
      max_idle      = VECS[v][27:12];
      irq_en        = 1'b1;
      cyc(1);
      base = pulses;
      got_char();
      ticks(int'(VECS[v][11:4]));
      cyc(2);
      check($sformatf("R3 vector %0d pulses", v), pulses - base, int'(VECS[v][3:0]));
      check($sformatf("R8 vector %0d flag", v), int'(irq_flag), int'(VECS[v][3:0]));
      clear_irq();
    end

    // R6 start bit cancels
    cfg_data_bits = 4'd8; cfg_parity_en = 1'b0; cfg_two_stop = 1'b0;
    max_idle = 16'd1;
    base = pulses;
    got_char(); ticks(5);
    rx_line = 1'b0; cyc(1); rx_line = 1'b1;
    ticks(20); cyc(2);
    check("R6 start edge cancels", pulses - base, 0);
    got_char(); ticks(10); cyc(2);
    check("R6 re-armed by next char", pulses - base, 1);
    clear_irq();

    // R7 reload mid period
    max_idle = 16'd2;
    base = pulses;
    got_char(); ticks(15);
    got_char(); ticks(15); cyc(2);
    check("R7 reload delays timeout", pulses - base, 0);
    ticks(5); cyc(2);
    check("R7 timeout after reload", pulses - base, 1);

    // R8 flag held until cleared
    cyc(20);
    check("R8 flag still set", int'(irq_flag), 1);
    clear_irq();
    check("R8 flag cleared", int'(irq_flag), 0);

    // R9 masked interrupt
    irq_en = 1'b0; max_idle = 16'd1;
    base = pulses;
    got_char(); ticks(10); cyc(2);
    check("R9 pulse while masked", pulses - base, 1);
    check("R9 flag stays low", int'(irq_flag), 0);

    // R3 exact pulse cycle: pulse seen right after the final tick edge
    irq_en = 1'b1;
    got_char(); ticks(9);
    bit_tick = 1'b1; cyc(1); bit_tick = 1'b0;
    check("R3 pulse cycle after last tick", int'(timeout_pulse), 1);
    cyc(1);
    check("R3 pulse one cycle wide", int'(timeout_pulse), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule